// File: doc/BRIEF.md
# Serial Register Programming Receiver

This block accepts a two-wire programming stream that arrives on a pair of pins which normally carry register-select levels. One pin is the serial clock and the other is the serial data. Both are brought into the system clock domain, and the block looks for clock edges there. It ignores all traffic until it sees an unlock preamble. After the preamble it accepts one framed word and then locks again.

Every bit is sent as a pair. On the falling serial-clock edge the data line carries the complement of the bit, and on the next rising edge it carries the true value. A frame is made of a start pair, 24 payload bits sent least significant first, and a stop pair. The first 21 payload bits form the register contents and the last 3 form the register address. A correct frame produces a one-cycle load strobe with the word. A malformed frame produces a one-cycle error strobe. An external inactivity watchdog and a power-down input can both abort a transfer.

Top module: `sprog_rx`

## Requirements
- R1: The receiver unlocks only after at least 5 rising serial-clock edges with data high, immediately followed by a rising edge with data low. While locked, no frame is accepted and neither strobe fires.
- R2: A rising edge with data low that arrives before 5 high rising edges have been counted restarts the high-edge count from zero.
- R3: After unlock, each payload bit is the data value at a rising edge, and the data value at the preceding falling edge must be its complement. A pair that is low at both edges raises `err_stb` for one cycle and locks the receiver.
- R4: The first pair after unlock must be a start pair (high at the falling edge, low at the rising edge). Any other first pair raises `err_stb` and locks the receiver.
- R5: Payload bits are taken least significant first. Payload bit k (k = 0..20) lands on `load_data[k]`, and payload bit 21+j (j = 0..2) lands on `load_addr[j]`.
- R6: A stop pair (high at both the falling and the rising edge) that follows exactly 24 payload bits raises `load_stb` for one cycle and updates `load_data` and `load_addr`. These outputs keep their value until the next load and are zero after reset.
- R7: A stop pair after fewer than 24 payload bits raises `err_stb` instead of a load. A 25th payload bit raises `err_stb` as soon as it arrives.
- R8: After any load or error the receiver is locked again, and a new preamble is needed before another frame is accepted.
- R9: A one-cycle `wdog_expire` pulse discards a partly received frame and locks the receiver. The bits that follow are not loaded.
- R10: While `pwr_down` is high, serial traffic is ignored, no strobe fires and the lock state is reset.
- R11: Each pin passes through two synchronizer flops and one edge-detect register. A strobe appears after the third system clock edge that follows the pin change completing the pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_pin | input | 1 | Serial clock pin (asynchronous) |
| sdat_pin | input | 1 | Serial data pin (asynchronous) |
| pwr_down | input | 1 | Power-down; blocks programming while high |
| wdog_expire | input | 1 | Inactivity timeout pulse from the external watchdog |
| load_stb | output | 1 | One-cycle strobe for a committed word |
| load_data | output | 21 | Register contents of the last committed word |
| load_addr | output | 3 | Register address of the last committed word |
| err_stb | output | 1 | One-cycle strobe for a malformed frame |

## Verification
On every cycle the assertions check four things. The load strobe is a single-cycle pulse, and the word outputs change only together with it. A load is committed only when the bit count was full. Every strobe, watchdog pulse and power-down cycle leaves the receiver locked with both strobes low. Whether the bit pairs are decoded correctly, where the bits land, and whether an interrupted preamble, a short frame or a long frame is rejected can only be shown by the bench's scenarios. In those scenarios a behavioural model follows the pins cycle by cycle, and scenario-level counts are compared against values fixed by hand.

// File: rtl/sprog_pkg.sv
// Shared types and default sizes for the serial programming receiver.
package sprog_pkg;
    localparam int DEF_DATA_W     = 21;
    localparam int DEF_ADDR_W     = 3;
    localparam int DEF_UNLOCK_MIN = 5;
    localparam int DEF_SYNC_STAGE = 2;

    // Frame receiver phase once the preamble has been seen.
    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_START = 2'd1,
        FR_SHIFT = 2'd2
    } fr_state_t;

    // Classification of one (falling sample, rising sample) pair.
    typedef enum logic [1:0] {
        PR_ZERO = 2'd0,
        PR_ONE  = 2'd1,
        PR_STOP = 2'd2,
        PR_BAD  = 2'd3
    } pair_t;
endpackage

// File: rtl/sprog_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pins.
// Assumes each bit is an independent level; STAGES must be at least 2.
module sprog_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift the pins through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], pin_i};
    end

    assign lvl_o = stg[STAGES-1];
endmodule

// File: rtl/sprog_edge.sv
// Edge detector for the synchronized serial clock.
// Compares the current synchronized level against the level one cycle earlier.
module sprog_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_q;

    // Remember the last synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/sprog_unlock.sv
// Preamble detector: counts rising serial-clock edges with data high and
// opens the receiver on a following data-low rising edge once MIN were seen.
// Assumes armed_i is high only while the frame receiver is idle.
module sprog_unlock #(
    parameter int MIN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic armed_i,
    input  logic rise_i,
    input  logic dat_i,
    output logic open_o
);
    localparam int CNT_W = $clog2(MIN + 1);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(MIN);

    logic [CNT_W-1:0] cnt;

    // Count high rising edges, saturating at MIN; restart on a low edge.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i || !armed_i) begin
            cnt <= '0;
        end else if (rise_i) begin
            if (dat_i) cnt <= (cnt == CAP) ? cnt : cnt + 1'b1;
            else       cnt <= '0;
        end
    end

    assign open_o = armed_i & rise_i & ~dat_i & (cnt == CAP);

    // A low rising edge while armed always leaves the count at zero.
    assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_i && rise_i && !dat_i) |=> (cnt == '0));
endmodule

// File: rtl/sprog_frame.sv
// Frame receiver: decodes complement/true bit pairs after unlock, checks the
// start pair, the bit count and the stop pair, and issues load or error.
// Assumes rise_i and fall_i are never high together.
module sprog_frame
    import sprog_pkg::*;
#(
    parameter int DATA_W = 21,
    parameter int ADDR_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear_i,
    input  logic                     open_i,
    input  logic                     rise_i,
    input  logic                     fall_i,
    input  logic                     dat_i,
    output logic                     active_o,
    output logic                     load_o,
    output logic                     err_o,
    output logic [DATA_W+ADDR_W-1:0] word_o
);
    localparam int WORD_W = DATA_W + ADDR_W;
    localparam int CNT_W  = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    fr_state_t         state;
    logic              fall_q;
    logic [CNT_W-1:0]  nbits;
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] word_q;
    logic              load_q;
    logic              err_q;
    pair_t             pair;

    // Classify the pair formed by the falling sample and the current data.
    always_comb begin
        unique case ({fall_q, dat_i})
            2'b10:   pair = PR_ZERO;
            2'b01:   pair = PR_ONE;
            2'b11:   pair = PR_STOP;
            default: pair = PR_BAD;
        endcase
    end

    // Frame sequencing, shifting and strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= FR_IDLE;
            fall_q <= 1'b0;
            nbits  <= '0;
            shreg  <= '0;
            word_q <= '0;
            load_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            load_q <= 1'b0;
            err_q  <= 1'b0;
            if (clear_i) begin
                state  <= FR_IDLE;
                fall_q <= 1'b0;
                nbits  <= '0;
            end else begin
                unique case (state)
                    FR_IDLE: begin
                        if (open_i) begin
                            state  <= FR_START;
                            fall_q <= 1'b0;
                        end
                    end
                    FR_START: begin
                        if (fall_i) begin
                            fall_q <= dat_i;
                        end else if (rise_i) begin
                            if (pair == PR_ZERO) begin
                                state <= FR_SHIFT;
                                nbits <= '0;
                            end else begin
                                err_q <= 1'b1;
                                state <= FR_IDLE;
                            end
                        end
                    end
                    FR_SHIFT: begin
                        if (fall_i) begin
                            fall_q <= dat_i;
                        end else if (rise_i) begin
                            if (pair == PR_STOP) begin
                                if (nbits == FULL) begin
                                    load_q <= 1'b1;
                                    word_q <= shreg;
                                end else begin
                                    err_q <= 1'b1;
                                end
                                state <= FR_IDLE;
                            end else if (pair == PR_BAD || nbits == FULL) begin
                                err_q <= 1'b1;
                                state <= FR_IDLE;
                            end else begin
                                shreg <= {dat_i, shreg[WORD_W-1:1]};
                                nbits <= nbits + 1'b1;
                            end
                        end
                    end
                    default: state <= FR_IDLE;
                endcase
            end
        end
    end

    assign active_o = (state != FR_IDLE);
    assign load_o   = load_q;
    assign err_o    = err_q;
    assign word_o   = word_q;

    // A locked receiver stays locked unless the preamble completes.
    assert_needs_unlock_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FR_IDLE && !open_i) |=> (state == FR_IDLE));
    // Load strobe lasts one cycle.
    assert_load_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_q |=> !load_q);
    // Word outputs move only with a load.
    assert_word_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load_q |-> $stable(word_q));
    // A load is committed only from a full bit count.
    assert_full_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_q |-> ($past(nbits) == FULL));
    // Any strobe leaves the receiver locked.
    assert_relock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_q || err_q) |-> (state == FR_IDLE));
    // A clear locks the receiver with no strobe.
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (state == FR_IDLE && !load_q && !err_q));
endmodule

// File: rtl/sprog_rx.sv
// Top of the serial programming receiver: synchronizes the two pins, finds
// serial-clock edges, detects the unlock preamble and receives one frame.
// Assumes pwr_down and wdog_expire are synchronous to clk.
module sprog_rx
    import sprog_pkg::*;
#(
    parameter int DATA_W      = DEF_DATA_W,
    parameter int ADDR_W      = DEF_ADDR_W,
    parameter int UNLOCK_MIN  = DEF_UNLOCK_MIN,
    parameter int SYNC_STAGES = DEF_SYNC_STAGE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_pin,
    input  logic              sdat_pin,
    input  logic              pwr_down,
    input  logic              wdog_expire,
    output logic              load_stb,
    output logic [DATA_W-1:0] load_data,
    output logic [ADDR_W-1:0] load_addr,
    output logic              err_stb
);
    localparam int WORD_W = DATA_W + ADDR_W;

    logic [1:0]        pins_s;
    logic              sck_rise;
    logic              sck_fall;
    logic              clear;
    logic              active;
    logic              open_pulse;
    logic [WORD_W-1:0] word;

    assign clear = pwr_down | wdog_expire;

    sprog_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({sdat_pin, sck_pin}),
        .lvl_o (pins_s)
    );

    sprog_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (pins_s[0]),
        .rise_o (sck_rise),
        .fall_o (sck_fall)
    );

    sprog_unlock #(.MIN(UNLOCK_MIN)) u_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .armed_i (~active),
        .rise_i  (sck_rise),
        .dat_i   (pins_s[1]),
        .open_o  (open_pulse)
    );

    sprog_frame #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear),
        .open_i   (open_pulse),
        .rise_i   (sck_rise),
        .fall_i   (sck_fall),
        .dat_i    (pins_s[1]),
        .active_o (active),
        .load_o   (load_stb),
        .err_o    (err_stb),
        .word_o   (word)
    );

    assign load_data = word[DATA_W-1:0];
    assign load_addr = word[WORD_W-1:DATA_W];

    // Power-down suppresses both strobes on the following cycle.
    assert_pd_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (!load_stb && !err_stb));
    // Load and error never coincide.
    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_stb && err_stb));
endmodule

// File: tb/sprog_rx_tb.sv
// Bench for sprog_rx: a behavioural model follows the pins every clock and
// directed scenarios check counts and words against hand-fixed values.
module sprog_rx_tb;
    localparam int HOLD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck_pin = 1'b0;
    logic        sdat_pin = 1'b0;
    logic        pwr_down = 1'b0;
    logic        wdog_expire = 1'b0;
    logic        load_stb;
    logic [20:0] load_data;
    logic [2:0]  load_addr;
    logic        err_stb;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit cmp_en = 1'b0;

    always #4 clk = ~clk;

    sprog_rx u_dut (
        .clk(clk), .rst_n(rst_n), .sck_pin(sck_pin), .sdat_pin(sdat_pin),
        .pwr_down(pwr_down), .wdog_expire(wdog_expire), .load_stb(load_stb),
        .load_data(load_data), .load_addr(load_addr), .err_stb(err_stb)
    );

    // Behavioural model state.
    bit c1, c2, c3, d1, d2;
    int mode, hic, nb;
    bit fv;
    logic [23:0] acc;
    logic [23:0] e_word;
    bit e_load, e_err;

    always @(posedge clk) begin
        bit rs, fl, d;
        if (!rst_n) begin
            c1 = 0; c2 = 0; c3 = 0; d1 = 0; d2 = 0;
            mode = 0; hic = 0; nb = 0; fv = 0; acc = '0;
            e_word = '0; e_load = 0; e_err = 0;
        end else begin
            rs = c2 && !c3;
            fl = !c2 && c3;
            d  = d2;
            e_load = 0;
            e_err  = 0;
            if (pwr_down || wdog_expire) begin
                mode = 0; hic = 0;
            end else if (mode == 0) begin
                if (rs) begin
                    if (d) begin
                        if (hic < 5) hic++;
                    end else begin
                        if (hic >= 5) begin mode = 1; fv = 0; end
                        hic = 0;
                    end
                end
            end else if (mode == 1) begin
                if (fl) fv = d;
                else if (rs) begin
                    if (fv && !d) begin mode = 2; nb = 0; acc = '0; end
                    else begin e_err = 1; mode = 0; end
                end
            end else begin
                if (fl) fv = d;
                else if (rs) begin
                    if (fv && d) begin
                        if (nb == 24) begin e_load = 1; e_word = acc; end
                        else e_err = 1;
                        mode = 0;
                    end else if (!fv && !d) begin
                        e_err = 1; mode = 0;
                    end else if (nb == 24) begin
                        e_err = 1; mode = 0;
                    end else begin
                        acc[nb] = d; nb++;
                    end
                end
            end
            c3 = c2; c2 = c1; c1 = sck_pin;
            d2 = d1; d1 = sdat_pin;
        end
    end

    // Event recorder and per-cycle comparison against the model (R11).
    int n_load = 0;
    int n_err = 0;
    logic [20:0] got_data = '0;
    logic [2:0]  got_addr = '0;

    always @(negedge clk) begin
        if (cmp_en) begin
            checks++;
            if (load_stb !== e_load || err_stb !== e_err ||
                load_data !== e_word[20:0] || load_addr !== e_word[23:21]) begin
                errors++;
                $display("FAIL R11 cycle %0d: load=%b err=%b data=%h addr=%h expected load=%b err=%b data=%h addr=%h",
                         cyc, load_stb, err_stb, load_data, load_addr,
                         e_load, e_err, e_word[20:0], e_word[23:21]);
            end
            if (load_stb === 1'b1) begin
                n_load++; got_data = load_data; got_addr = load_addr;
            end
            if (err_stb === 1'b1) n_err++;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic setp(input logic c, input logic d);
        sck_pin = c;
        sdat_pin = d;
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic preamble(input int highs);
        for (int i = 0; i < highs; i++) begin
            setp(0, 1);
            setp(1, 1);
        end
        setp(0, 1);
        setp(0, 0);
        setp(1, 0);
    endtask

    task automatic send_pair(input logic f, input logic r);
        setp(1, f);
        setp(0, f);
        setp(0, r);
        setp(1, r);
    endtask

    task automatic send_frame(input logic [31:0] w, input int n, input bit stop);
        send_pair(1, 0);
        for (int i = 0; i < n; i++) send_pair(!w[i], w[i]);
        if (stop) send_pair(1, 1);
    endtask

    int bl, be;
    task automatic mark();
        bl = n_load; be = n_err;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        cmp_en = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state of the outputs (R6).
        check_int("R6 reset load_stb", int'(load_stb), 0);
        check_int("R6 reset err_stb", int'(err_stb), 0);
        check_int("R6 reset data", int'(load_data), 0);

        // R1 R5 R6: exactly five highs, then a valid frame.
        mark();
        preamble(5);
        send_frame({8'h0, 3'd5, 21'h1A5C3}, 24, 1);
        check_int("R6 one load", n_load - bl, 1);
        check_int("R5 data bits", int'(got_data), 'h1A5C3);
        check_int("R5 addr bits", int'(got_addr), 5);
        check_int("R1 no error", n_err - be, 0);

        // R1: a longer preamble also unlocks.
        mark();
        preamble(8);
        send_frame({8'h0, 3'd2, 21'h0F0F0}, 24, 1);
        check_int("R1 long preamble load", n_load - bl, 1);
        check_int("R5 data second word", int'(got_data), 'h0F0F0);
        check_int("R5 addr second word", int'(got_addr), 2);

        // R2: preamble interrupted at 3, then 2 more highs; no unlock.
        mark();
        preamble(3);
        preamble(2);
        send_frame(32'h0, 24, 1);
        check_int("R2 no load", n_load - bl, 0);
        check_int("R2 no error", n_err - be, 0);
        check_int("R6 data held", int'(got_data), 'h0F0F0);

        // R8: after a load a frame with no preamble is ignored.
        preamble(5);
        send_frame({8'h0, 3'd7, 21'h155555}, 24, 1);
        mark();
        send_frame(32'h3, 24, 1);
        check_int("R8 relocked after load", n_load - bl, 0);
        check_int("R8 no error", n_err - be, 0);

        // R3: a pair low at both edges is an error.
        mark();
        preamble(5);
        send_pair(1, 0);
        send_pair(0, 1);
        send_pair(1, 0);
        send_pair(0, 1);
        send_pair(0, 0);
        check_int("R3 bad pair error", n_err - be, 1);
        check_int("R3 no load", n_load - bl, 0);

        // R4: a missing start pair is an error.
        mark();
        preamble(5);
        send_pair(0, 1);
        check_int("R4 bad start error", n_err - be, 1);

        // R7: short frame then stop.
        mark();
        preamble(5);
        send_frame(32'h2AA, 10, 1);
        check_int("R7 short frame error", n_err - be, 1);
        check_int("R7 short frame no load", n_load - bl, 0);

        // R7: a 25th bit.
        mark();
        preamble(5);
        send_frame(32'h0ABCDEF, 25, 1);
        check_int("R7 long frame error", n_err - be, 1);
        check_int("R7 long frame no load", n_load - bl, 0);

        // R9: watchdog in mid-frame discards it.
        mark();
        preamble(5);
        send_pair(1, 0);
        for (int i = 0; i < 10; i++) send_pair(i[0], !i[0]);
        wdog_expire = 1'b1;
        @(negedge clk);
        wdog_expire = 1'b0;
        for (int i = 0; i < 14; i++) send_pair(1, 0);
        send_pair(1, 1);
        check_int("R9 no load after timeout", n_load - bl, 0);
        check_int("R9 no error after timeout", n_err - be, 0);
        mark();
        preamble(5);
        send_frame({8'h0, 3'd3, 21'h000ABC}, 24, 1);
        check_int("R9 recovery load", n_load - bl, 1);
        check_int("R5 recovery data", int'(got_data), 'h000ABC);

        // R10: power-down blocks programming.
        mark();
        pwr_down = 1'b1;
        preamble(5);
        send_frame({8'h0, 3'd1, 21'h1FFFFF}, 24, 1);
        pwr_down = 1'b0;
        repeat (HOLD) @(negedge clk);
        check_int("R10 no load in power-down", n_load - bl, 0);
        check_int("R10 no error in power-down", n_err - be, 0);
        check_int("R10 data untouched", int'(got_data), 'h000ABC);
        mark();
        preamble(6);
        send_frame({8'h0, 3'd6, 21'h100001}, 24, 1);
        check_int("R10 load after power-up", n_load - bl, 1);
        check_int("R5 edge bits data", int'(load_data), 'h100001);
        check_int("R5 edge bits addr", int'(load_addr), 6);

        repeat (8) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule